// File: doc/BRIEF.md
# PLL Feedback Divider Ramp Controller

This block moves a running PLL to a new feedback divider value N. It does not write the new value abruptly. It hands the change to the PLL's built-in dynamic ramp, which slews the frequency. A start strobe carries the requested N. The controller then performs a fixed series of register updates:

1. It loads the two ramp step sizes.
2. It enters slowdown mode.
3. It rewrites only the N field of the coefficient register.
4. It enables the ramp.
5. It polls a ramp-complete status at a programmable interval.

When the poll ends, the controller leaves slowdown and ramp mode together. It then reports completion, and flags a timeout if the poll limit was reached.

The surrounding logic owns the coefficient register. It presents the current value on `coeff_i` and applies `coeff_wdata_o` when `coeff_we_o` pulses. The step sizes, the slowdown bit and the ramp-enable bit are held inside the block as outputs. A request whose N already matches the coefficient register completes without touching anything.

Top module: `ndiv_ramp_ctrl`

## Requirements
- R1: If `n_req_i` equals bits 15:8 of `coeff_i` when `start_i` is sampled, the block performs no write and sets neither slowdown nor ramp-enable. `done_o` rises one cycle after the start edge, with `timeout_o` low.
- R2: Before the coefficient write, `step_a_o` holds 0x2B and `step_b_o` holds 0x0B.
- R3: `slowdown_o` rises before the single coefficient write pulse. `coeff_wdata_o` equals `coeff_i` with bits 15:8 replaced by the requested N, so bits 7:0 (M) and 21:16 (post divider) are unchanged.
- R4: `ramp_en_o` rises the cycle after the coefficient write. Polls of `ramp_done_i` occur every `poll_gap_i`+1 cycles. If the ramp is already complete at the first poll, `done_o` rises `poll_gap_i`+7 cycles after the start edge.
- R5: At most 500 polls are made. On a timeout, `done_o` rises (`poll_gap_i`+1)*500+6 cycles after the start edge.
- R6: `slowdown_o` and `ramp_en_o` fall in the same cycle, on success and on timeout alike.
- R7: `done_o` is a one-cycle pulse issued after the exit step. `timeout_o` is high only together with `done_o`, and only when the poll limit ran out.
- R8: A `start_i` pulse while `busy_o` is high has no effect on the write or the final N.
- R9: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| n_req_i | input | 8 | Requested feedback divider |
| poll_gap_i | input | 4 | Extra cycles between polls |
| coeff_i | input | 32 | Current coefficient register value |
| ramp_done_i | input | 1 | Synchronized ramp-complete status |
| coeff_we_o | output | 1 | Coefficient register write pulse |
| coeff_wdata_o | output | 32 | Coefficient write data |
| step_a_o | output | 8 | Ramp step size A |
| step_b_o | output | 8 | Ramp step size B |
| slowdown_o | output | 1 | Slowdown-using-PLL mode |
| ramp_en_o | output | 1 | Dynamic ramp enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Poll limit exhausted, with done |

## Verification
The hardest state to reach is the exhausted poll counter. The ramp status must stay low through all 500 polls, which takes thousands of cycles when the poll gap is large. The bench models the ramp as a counter that asserts the complete status a chosen number of cycles after the ramp is enabled. Setting a delay far beyond the poll window forces the timeout path. The exact latency is checked for both a short and a long gap. A second start strobe injected mid-ramp covers the ignored-request case.

// File: rtl/ndr_pkg.sv
package ndr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_STEP, S_SLOW, S_PROG, S_RAMP, S_POLL, S_EXIT, S_FIN
  } ndr_state_e;
endpackage

// File: rtl/ndr_coeff_merge.sv
module ndr_coeff_merge #(
  parameter int COEFF_W = 32,
  parameter int N_LSB   = 8,
  parameter int N_W     = 8
) (
  input  logic [COEFF_W-1:0] coeff_i,
  input  logic [N_W-1:0]     n_cmp_i,
  input  logic [N_W-1:0]     n_ins_i,
  output logic               same_o,
  output logic [COEFF_W-1:0] merged_o
);
  assign same_o = (coeff_i[N_LSB +: N_W] == n_cmp_i);

  always_comb begin
    merged_o = coeff_i;
    merged_o[N_LSB +: N_W] = n_ins_i;
  end
endmodule

// File: rtl/ndr_poll_timer.sv
module ndr_poll_timer #(
  parameter int MAX_POLLS = 500,
  parameter int GAP_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             ramp_done_i,
  output logic             exit_o,
  output logic             expired_o
);
  localparam int TRY_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_POLLS - 1);

  logic             running_q;
  logic [GAP_W-1:0] gap_q, gap_cnt_q;
  logic [TRY_W-1:0] tries_q;
  logic             poll, last;

  assign poll      = running_q && (gap_cnt_q == gap_q);
  assign last      = (tries_q == LAST_TRY);
  assign exit_o    = poll && (ramp_done_i || last);
  assign expired_o = poll && !ramp_done_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      gap_q     <= '0;
      gap_cnt_q <= '0;
      tries_q   <= '0;
    end else if (arm_i) begin
      running_q <= 1'b1;
      gap_q     <= gap_i;
      gap_cnt_q <= '0;
      tries_q   <= '0;
    end else if (running_q) begin
      if (poll) begin
        gap_cnt_q <= '0;
        if (exit_o) running_q <= 1'b0;
        else        tries_q   <= tries_q + 1'b1;
      end else begin
        gap_cnt_q <= gap_cnt_q + 1'b1;
      end
    end
  end

  // R5
  poll_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q <= LAST_TRY);

  // R5
  stop_after_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_o && !arm_i) |=> !running_q);
endmodule

// File: rtl/ndr_seq.sv
module ndr_seq
  import ndr_pkg::*;
#(
  parameter int              COEFF_W = 32,
  parameter int              N_W     = 8,
  parameter int              STEP_W  = 8,
  parameter logic [STEP_W-1:0] STEP_A = 8'h2B,
  parameter logic [STEP_W-1:0] STEP_B = 8'h0B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_W-1:0]     n_req_i,
  input  logic               same_i,
  input  logic [COEFF_W-1:0] merged_i,
  input  logic               exit_i,
  input  logic               expired_i,
  output logic [N_W-1:0]     n_hold_o,
  output logic               arm_o,
  output logic               coeff_we_o,
  output logic [COEFF_W-1:0] coeff_wdata_o,
  output logic [STEP_W-1:0]  step_a_o,
  output logic [STEP_W-1:0]  step_b_o,
  output logic               slowdown_o,
  output logic               ramp_en_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o
);
  ndr_state_e state_q;
  logic       tmo_q;

  assign arm_o  = (state_q == S_RAMP);
  assign busy_o = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= S_IDLE;
      n_hold_o      <= '0;
      tmo_q         <= 1'b0;
      coeff_we_o    <= 1'b0;
      coeff_wdata_o <= '0;
      step_a_o      <= '0;
      step_b_o      <= '0;
      slowdown_o    <= 1'b0;
      ramp_en_o     <= 1'b0;
      done_o        <= 1'b0;
      timeout_o     <= 1'b0;
    end else begin
      coeff_we_o <= 1'b0;
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          n_hold_o <= n_req_i;
          tmo_q    <= 1'b0;
          state_q  <= same_i ? S_FIN : S_STEP;
        end
        S_STEP: begin
          step_a_o <= STEP_A;
          step_b_o <= STEP_B;
          state_q  <= S_SLOW;
        end
        S_SLOW: begin
          slowdown_o <= 1'b1;
          state_q    <= S_PROG;
        end
        S_PROG: begin
          coeff_we_o    <= 1'b1;
          coeff_wdata_o <= merged_i;
          state_q       <= S_RAMP;
        end
        S_RAMP: begin
          ramp_en_o <= 1'b1;
          state_q   <= S_POLL;
        end
        S_POLL: if (exit_i) begin
          tmo_q   <= expired_i;
          state_q <= S_EXIT;
        end
        S_EXIT: begin
          slowdown_o <= 1'b0;
          ramp_en_o  <= 1'b0;
          state_q    <= S_FIN;
        end
        S_FIN: begin
          done_o    <= 1'b1;
          timeout_o <= tmo_q;
          state_q   <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2
  steps_before_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coeff_we_o |-> (step_a_o == STEP_A) && (step_b_o == STEP_B));

  // R3
  slow_before_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coeff_we_o |-> slowdown_o && !ramp_en_o);

  // R4
  ramp_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ramp_en_o) |-> $past(coeff_we_o) && slowdown_o);

  // R6
  joint_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slowdown_o) |-> $fell(ramp_en_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  timeout_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o && !slowdown_o && !ramp_en_o);
endmodule

// File: rtl/ndiv_ramp_ctrl.sv
module ndiv_ramp_ctrl #(
  parameter int                COEFF_W   = 32,
  parameter int                N_LSB     = 8,
  parameter int                N_W       = 8,
  parameter int                STEP_W    = 8,
  parameter logic [STEP_W-1:0] STEP_A    = 8'h2B,
  parameter logic [STEP_W-1:0] STEP_B    = 8'h0B,
  parameter int                MAX_POLLS = 500,
  parameter int                GAP_W     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_W-1:0]     n_req_i,
  input  logic [GAP_W-1:0]   poll_gap_i,
  input  logic [COEFF_W-1:0] coeff_i,
  input  logic               ramp_done_i,
  output logic               coeff_we_o,
  output logic [COEFF_W-1:0] coeff_wdata_o,
  output logic [STEP_W-1:0]  step_a_o,
  output logic [STEP_W-1:0]  step_b_o,
  output logic               slowdown_o,
  output logic               ramp_en_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o
);
  logic               same, arm, poll_exit, poll_expired;
  logic [N_W-1:0]     n_hold;
  logic [COEFF_W-1:0] merged;

  ndr_coeff_merge #(.COEFF_W(COEFF_W), .N_LSB(N_LSB), .N_W(N_W)) merge_i (
    .coeff_i  (coeff_i),
    .n_cmp_i  (n_req_i),
    .n_ins_i  (n_hold),
    .same_o   (same),
    .merged_o (merged)
  );

  ndr_poll_timer #(.MAX_POLLS(MAX_POLLS), .GAP_W(GAP_W)) timer_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm),
    .gap_i       (poll_gap_i),
    .ramp_done_i (ramp_done_i),
    .exit_o      (poll_exit),
    .expired_o   (poll_expired)
  );

  ndr_seq #(
    .COEFF_W(COEFF_W), .N_W(N_W), .STEP_W(STEP_W), .STEP_A(STEP_A), .STEP_B(STEP_B)
  ) seq_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .n_req_i       (n_req_i),
    .same_i        (same),
    .merged_i      (merged),
    .exit_i        (poll_exit),
    .expired_i     (poll_expired),
    .n_hold_o      (n_hold),
    .arm_o         (arm),
    .coeff_we_o    (coeff_we_o),
    .coeff_wdata_o (coeff_wdata_o),
    .step_a_o      (step_a_o),
    .step_b_o      (step_b_o),
    .slowdown_o    (slowdown_o),
    .ramp_en_o     (ramp_en_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .timeout_o     (timeout_o)
  );

  // R1
  no_write_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o) |-> !coeff_we_o && !ramp_en_o);

  // R3
  write_keeps_other_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coeff_we_o |-> ((coeff_wdata_o ^ coeff_i) & ~(((COEFF_W)'(1) << N_LSB) * ((COEFF_W)'(1) << N_W) - ((COEFF_W)'(1) << N_LSB))) == '0);
endmodule

// File: tb/ndiv_ramp_ctrl_tb_top.sv
module ndiv_ramp_ctrl_tb_top;
  localparam int MAXP = 500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  n_req = '0;
  logic [3:0]  gap = '0;
  logic [31:0] coeff_reg = '0;
  logic        ramp_done;
  logic        we;
  logic [31:0] wdata;
  logic [7:0]  step_a, step_b;
  logic        slowdown, ramp_en, busy, done, tmo;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int dly_r = 0;
  int en_cnt = 0;

  int sd_rise, re_rise, sd_fall, re_fall, we_cyc, we_n, done_n;
  bit step_ok;
  logic sd_prev = 1'b0, re_prev = 1'b0;

  always #5 clk = ~clk;

  ndiv_ramp_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .n_req_i(n_req),
    .poll_gap_i(gap), .coeff_i(coeff_reg), .ramp_done_i(ramp_done),
    .coeff_we_o(we), .coeff_wdata_o(wdata), .step_a_o(step_a), .step_b_o(step_b),
    .slowdown_o(slowdown), .ramp_en_o(ramp_en), .busy_o(busy), .done_o(done),
    .timeout_o(tmo)
  );

  assign ramp_done = ramp_en && (en_cnt >= dly_r);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    en_cnt <= ramp_en ? en_cnt + 1 : 0;
    if (we) coeff_reg <= wdata;
  end

  always @(negedge clk) begin
    if (slowdown && !sd_prev) sd_rise = cyc;
    if (!slowdown && sd_prev) sd_fall = cyc;
    if (ramp_en && !re_prev) re_rise = cyc;
    if (!ramp_en && re_prev) re_fall = cyc;
    if (we) begin
      we_n++;
      we_cyc = cyc;
      step_ok = (step_a == 8'h2B) && (step_b == 8'h0B);
    end
    if (done) done_n++;
    sd_prev = slowdown;
    re_prev = ramp_en;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    sd_rise = 0; re_rise = 0; sd_fall = 0; re_fall = 0;
    we_cyc = 0; we_n = 0; done_n = 0; step_ok = 1'b0;
  endtask

  task automatic launch(input logic [31:0] c0, input logic [7:0] n, input logic [3:0] g,
                        input int d, output int s_cyc);
    @(negedge clk);
    coeff_reg = c0;
    dly_r = d;
    clr_mon();
    start = 1'b1; n_req = n; gap = g;
    @(negedge clk);
    start = 1'b0;
    s_cyc = cyc;
  endtask

  task automatic wait_done(output int lat, input int s_cyc);
    int guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    lat = cyc - s_cyc;
  endtask

  typedef struct packed {
    logic [31:0] c0;
    logic [7:0]  n;
    logic [3:0]  g;
    logic [15:0] d;
    logic        tmo;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{32'h000A_3C02, 8'h50, 4'd0,  16'd0,     1'b0},
    '{32'h0011_5007, 8'h20, 4'd3,  16'd0,     1'b0},
    '{32'h0005_2003, 8'h20, 4'd2,  16'd0,     1'b0},
    '{32'h003F_1AFF, 8'hC8, 4'd2,  16'd7,     1'b0},
    '{32'h0001_8001, 8'h10, 4'd0,  16'd60000, 1'b1},
    '{32'h0022_4404, 8'h45, 4'd15, 16'd60000, 1'b1}
  };

  initial begin
    int s, lat, exp_lat;
    bit same;
    repeat (3) @(negedge clk);
    // R9
    chk(!we && !slowdown && !ramp_en && !busy && !done && !tmo && step_a == 0 && step_b == 0,
        "R9 reset outputs", {we, slowdown, ramp_en, busy, done, tmo}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      same = (VEC[i].c0[15:8] == VEC[i].n);
      launch(VEC[i].c0, VEC[i].n, VEC[i].g, int'(VEC[i].d), s);
      wait_done(lat, s);
      chk(tmo == VEC[i].tmo, "R7 timeout flag", tmo, VEC[i].tmo);
      chk(coeff_reg[15:8] == VEC[i].n, "R3 final N", coeff_reg[15:8], VEC[i].n);
      chk((coeff_reg & 32'hFFFF_00FF) == (VEC[i].c0 & 32'hFFFF_00FF), "R3 M/PL kept",
          coeff_reg, VEC[i].c0);
      chk(!slowdown && !ramp_en, "R6 modes off at done", {slowdown, ramp_en}, 0);
      if (same) begin
        chk(we_n == 0 && sd_rise == 0, "R1 no write no slowdown", we_n, 0);
        chk(lat == 1, "R1 latency", lat, 1);
      end else begin
        chk(we_n == 1, "R3 one write", we_n, 1);
        chk(step_ok, "R2 steps at write", {step_a, step_b}, 16'h2B0B);
        chk(sd_rise != 0 && sd_rise < we_cyc, "R3 slowdown first", sd_rise, we_cyc);
        chk(re_rise == we_cyc + 1, "R4 ramp after write", re_rise, we_cyc + 1);
        chk(sd_fall == re_fall && sd_fall != 0, "R6 joint exit", sd_fall, re_fall);
        if (VEC[i].tmo) exp_lat = (int'(VEC[i].g) + 1) * MAXP + 6;
        else if (VEC[i].d == 0) exp_lat = int'(VEC[i].g) + 7;
        else exp_lat = lat;
        chk(lat == exp_lat, VEC[i].tmo ? "R5 timeout latency" : "R4 poll latency", lat, exp_lat);
      end
      @(negedge clk);
      chk(!done && !tmo && done_n == 1, "R7 single done pulse", done_n, 1);
    end

    // R8: second start while busy is ignored
    launch(32'h0003_3003, 8'h40, 4'd1, 20, s);
    repeat (4) @(negedge clk);
    chk(busy, "R8 busy mid-ramp", busy, 1);
    start = 1'b1; n_req = 8'h77;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat, s);
    chk(coeff_reg[15:8] == 8'h40 && we_n == 1, "R8 start ignored", coeff_reg[15:8], 8'h40);
    chk(!tmo, "R8 no timeout", tmo, 0);
    @(negedge clk);
    chk(!busy && !done, "R8 back to idle", {busy, done}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule